// File: doc/BRIEF.md
# SMBus Alert Pin and Alert-Response Responder

This block owns the alert output of a temperature-monitor SMBus slave and its side of the SMBus Alert Response Address (ARA) exchange. Status events arrive as single-cycle set pulses. In interrupt mode they pull the open-drain, active-low alert line down. The alert stays down until a host claims it through the ARA. When the host addresses the bus at the ARA with the read bit set, the block acknowledges and returns its own 7-bit address with a zero in the least significant bit. It watches SDA on every bit it releases, so that it can back off if another device wins arbitration.

A returned address that completes without contention sets an internal mask, which releases the alert. This happens only if the status register is empty at that moment. Otherwise the host must first clear the status with a status-read strobe and then repeat the ARA. Any new status bit clears the mask again. In comparator mode the alert follows the status register directly. In tachometer mode the pin is released. The block answers the ARA in neither of these modes.

A transfer that stalls with SCL held low for a programmable number of clock cycles puts the slave state machine back to idle and releases SDA. SCL and SDA are sampled as synchronous inputs. The open-drain outputs are modelled as enables: an enable of 1 means the line is pulled low. No data stream crosses the block's edge, so it has no valid/ready port. Every pin is a plain control or status signal.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset, both alert_oe_o and sda_oe_o are 0.
- R2: In interrupt mode (pin_mode_i = 0), alert_oe_o becomes 1 in the cycle after any stat_set_i bit is set. It stays 1 until the mask is set, and a status read alone does not release it.
- R3: The block acknowledges an address byte equal to 0x19 (7-bit address 0001100, read bit 1) only when it is in interrupt mode and alert_oe_o is 1. It then drives the byte {DEV_ADDR, 0} (0x98 by default) MSB first, one bit per SCL clock. It drives SDA low only while SCL is low.
- R4: In comparator mode (pin_mode_i = 1), alert_oe_o equals "status register non-zero". In tachometer mode (pin_mode_i = 2 or 3), alert_oe_o is 0. In neither mode is the ARA acknowledged.
- R5: Any other address byte, including the device's own address, gets no acknowledge and leaves the alert output unchanged.
- R6: While returning its address, if the block has released SDA for a 1 and samples SDA low at the SCL rising edge, it stops driving for the rest of the transfer and does not set the mask.
- R7: The transfer completes at the rising SCL edge of the master's acknowledge bit that follows the 8th returned bit. At completion the mask is set only if the status register is empty. Otherwise the mask stays clear.
- R8: A stat_rd_i pulse clears the status register. Bits set in the same cycle survive. Any new status bit clears the mask.
- R9: If SCL stays low for TIMEOUT_CYC consecutive clocks while a transfer is in progress, the slave returns to idle and releases SDA. The next START is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe_o | output | 1 | SDA pull-down enable (1 = drive low) |
| pin_mode_i | input | 2 | Alert pin mode: 0 interrupt, 1 comparator, 2/3 tachometer input |
| stat_set_i | input | STAT_W | Per-bit status set pulses |
| stat_rd_i | input | 1 | Status-register read strobe (clears status) |
| alert_oe_o | output | 1 | Alert pull-down enable (1 = alert asserted) |

## Verification
The assertions assume three things about the inputs. SCL and SDA are already synchronous to clk. The master changes SDA only while SCL is low, except for START and STOP. pin_mode_i holds steady while a transfer is in progress. The bench keeps to these rules. It moves the bus lines only on falling clock edges, and it sets SDA in the low half of each SCL period. It changes the mode only between transfers, after a STOP. Contention comes from a second open-drain pull-down that the bench asserts only while SCL is low.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;
  typedef enum logic [1:0] {
    PIN_INTR = 2'd0,
    PIN_CMP  = 2'd1,
    PIN_TACH = 2'd2
  } pin_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } slv_state_e;
endpackage

// File: rtl/smb_line_sense.sv
module smb_line_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
  parameter int TIMEOUT_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic scl_i,
  output logic expire_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          stalled;

  assign stalled  = busy_i & ~scl_i;
  assign expire_o = stalled & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (!stalled || expire_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/smb_alert_ctrl.sv
module smb_alert_ctrl
  import smb_alert_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pin_mode_i,
  input  logic [STAT_W-1:0] stat_set_i,
  input  logic              stat_rd_i,
  input  logic              ara_done_i,
  output logic              alert_oe_o,
  output logic              mask_o,
  output logic              stat_empty_o
);
  logic [STAT_W-1:0] status_q;
  logic              flag_q, mask_q, new_bit;

  assign new_bit      = |stat_set_i;
  assign stat_empty_o = (status_q == '0);
  assign mask_o       = mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      flag_q   <= 1'b0;
      mask_q   <= 1'b0;
    end else begin
      status_q <= (status_q & ~{STAT_W{stat_rd_i}}) | stat_set_i;
      if (new_bit) flag_q <= 1'b1;
      if (new_bit)                          mask_q <= 1'b0;
      else if (ara_done_i && stat_empty_o)  mask_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (pin_mode_i)
      PIN_INTR: alert_oe_o = flag_q & ~mask_q;
      PIN_CMP:  alert_oe_o = ~stat_empty_o;
      default:  alert_oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder
  import smb_alert_pkg::*;
#(
  parameter int         STAT_W      = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h4C,
  parameter logic [6:0] ARA_ADDR    = 7'h0C,
  parameter int         TIMEOUT_CYC = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        pin_mode_i,
  input  logic [STAT_W-1:0] stat_set_i,
  input  logic              stat_rd_i,
  output logic              alert_oe_o
);
  localparam logic [7:0] TX_BYTE  = {DEV_ADDR, 1'b0};
  localparam logic [7:0] ARA_READ = {ARA_ADDR, 1'b1};

  logic       scl_rise, scl_fall, bus_start, bus_stop, tmo;
  logic       busy_w, mask_w, stat_empty_w, ara_done;
  logic       addr_hit;
  slv_state_e st_q;
  logic [2:0] bit_cnt_q;
  logic [7:0] rx_q, tx_q;
  logic       oe_q;

  smb_line_sense u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  assign busy_w = (st_q != ST_IDLE);

  smb_idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_w), .scl_i(scl_i), .expire_o(tmo)
  );

  assign ara_done = (st_q == ST_MACK) & scl_rise;

  smb_alert_ctrl #(.STAT_W(STAT_W)) u_alert (
    .clk(clk), .rst_n(rst_n), .pin_mode_i(pin_mode_i),
    .stat_set_i(stat_set_i), .stat_rd_i(stat_rd_i), .ara_done_i(ara_done),
    .alert_oe_o(alert_oe_o), .mask_o(mask_w), .stat_empty_o(stat_empty_w)
  );

  // Address match also requires the alert to be live in interrupt mode.
  assign addr_hit = ({rx_q[6:0], sda_i} == ARA_READ) &&
                    (pin_mode_i == PIN_INTR) && alert_oe_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      oe_q      <= 1'b0;
    end else if (bus_stop || tmo) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else if (bus_start) begin
      st_q      <= ST_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: if (scl_rise) begin
          rx_q <= {rx_q[6:0], sda_i};
          if (bit_cnt_q == 3'd7) begin
            st_q      <= addr_hit ? ST_ACK_WAIT : ST_IGNORE;
            bit_cnt_q <= '0;
          end else begin
            bit_cnt_q <= bit_cnt_q + 3'd1;
          end
        end
        ST_ACK_WAIT: if (scl_fall) begin
          oe_q <= 1'b1;
          st_q <= ST_ACK;
        end
        ST_ACK: if (scl_fall) begin
          oe_q      <= ~TX_BYTE[7];
          tx_q      <= {TX_BYTE[6:0], 1'b0};
          bit_cnt_q <= '0;
          st_q      <= ST_TX;
        end
        ST_TX: begin
          if (scl_rise && !oe_q && !sda_i) begin
            st_q <= ST_IGNORE;
          end else if (scl_fall) begin
            if (bit_cnt_q == 3'd7) begin
              oe_q <= 1'b0;
              st_q <= ST_MACK;
            end else begin
              oe_q      <= ~tx_q[7];
              tx_q      <= {tx_q[6:0], 1'b0};
              bit_cnt_q <= bit_cnt_q + 3'd1;
            end
          end
        end
        ST_MACK: if (scl_rise) st_q <= ST_IGNORE;
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/smb_alert_responder_chk.sv
module smb_alert_responder_chk
  import smb_alert_pkg::*;
#(
  parameter int TIMEOUT_CYC = 250000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic       alert_oe_o,
  input logic [1:0] pin_mode_i,
  input logic       mask_w,
  input logic       stat_empty_w,
  input logic       busy_w
);
  localparam int CW = $clog2(TIMEOUT_CYC + 3);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  low_cnt <= '0;
    else if (!busy_w || scl_i)   low_cnt <= '0;
    else if (low_cnt != CW'(TIMEOUT_CYC + 2)) low_cnt <= low_cnt + 1'b1;
  end

  AST_DRIVE_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !$past(scl_i)); // R3
  AST_DRIVE_ONLY_INTR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> ($past(pin_mode_i) == PIN_INTR)); // R3
  AST_TACH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mode_i[1] == 1'b1) |-> !alert_oe_o); // R4
  AST_MASK_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_w) |-> $past(stat_empty_w)); // R7
  AST_STALL_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    (low_cnt == CW'(TIMEOUT_CYC + 2)) |-> !sda_oe_o); // R9
endmodule

bind smb_alert_responder smb_alert_responder_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .alert_oe_o(alert_oe_o), .pin_mode_i(pin_mode_i), .mask_w(mask_w),
  .stat_empty_w(stat_empty_w), .busy_w(busy_w)
);

// File: tb/smb_alert_responder_tb.sv
module smb_alert_responder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STAT_W     = 8;
  localparam int TMO        = 64;
  localparam logic [7:0] ARA_RD  = 8'h19;
  localparam logic [7:0] OWN_WR  = 8'h98;
  localparam logic [7:0] RET_EXP = 8'h98;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, contend = 1'b0;
  logic [1:0] pin_mode = 2'd0;
  logic [STAT_W-1:0] stat_set = '0;
  logic stat_rd = 1'b0;
  wire  sda_oe, alert_oe;
  wire  sda_line = sda_m & ~sda_oe & ~contend;

  int n_chk = 0, n_fail = 0;
  bit run = 1'b0;

  // behavioural model state
  int m_status = 0;
  bit m_flag = 0, m_mask = 0, m_scl_prev = 1, expect_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_alert_responder #(.STAT_W(STAT_W), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .pin_mode_i(pin_mode), .stat_set_i(stat_set),
    .stat_rd_i(stat_rd), .alert_oe_o(alert_oe)
  );

  always @(posedge clk) begin
    if (run) begin
      bit fin;
      fin = expect_done && scl_m && !m_scl_prev;
      if (fin) expect_done = 0;
      if (stat_set != 0)              m_mask = 0;
      else if (fin && m_status == 0)  m_mask = 1;
      if (stat_set != 0) m_flag = 1;
      m_status = (stat_rd ? 0 : m_status) | int'(stat_set);
    end
    m_scl_prev = scl_m;
  end

  function automatic bit model_alert();
    if (pin_mode == 2'd0) return m_flag && !m_mask;
    if (pin_mode == 2'd1) return m_status != 0;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (run) check("R2/R4/R7/R8 model alert_oe", int'(alert_oe), int'(model_alert()));
  end

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; w(3); sda_m = 0; w(3); scl_m = 0; w(1);
  endtask
  task automatic bus_stop();
    sda_m = 0; w(2); scl_m = 1; w(2); sda_m = 1; w(3);
  endtask
  task automatic send_bit(input bit b);
    sda_m = b; w(2); scl_m = 1; w(3); scl_m = 0; w(1);
  endtask
  task automatic recv_bit(input bit pull, output bit b);
    sda_m = 1; contend = pull; w(2); scl_m = 1; w(2); b = sda_line;
    w(1); scl_m = 0; w(1); contend = 0;
  endtask

  task automatic txn(input logic [7:0] abyte, input int contend_bit,
                     output bit acked, output logic [7:0] data);
    bit b;
    data = 8'h00;
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(abyte[i]);
    recv_bit(0, b);
    acked = !b;
    if (acked) begin
      for (int i = 0; i < 8; i++) begin
        recv_bit(i == contend_bit, b);
        data = {data[6:0], b};
      end
      if (contend_bit < 0) expect_done = 1;
      send_bit(1'b1);
      expect_done = 0;
    end
    bus_stop();
  endtask

  task automatic pulse(input logic [STAT_W-1:0] s, input bit rd);
    stat_set = s; stat_rd = rd; w(1); stat_set = '0; stat_rd = 0; w(2);
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    w(3); rst_n = 1; w(1);
    check("R1 alert_oe after reset", int'(alert_oe), 0);
    check("R1 sda_oe after reset", int'(sda_oe), 0);
    run = 1;

    txn(ARA_RD, -1, ack, d);
    check("R3 no ack while alert idle", int'(ack), 0);

    pulse(8'h01, 0);
    check("R2 alert asserted on status set", int'(alert_oe), 1);

    txn(ARA_RD, -1, ack, d);
    check("R3 ara acked", int'(ack), 1);
    check("R3 returned address", int'(d), int'(RET_EXP));
    check("R7 not masked with status pending", int'(alert_oe), 1);

    pulse('0, 1);
    check("R2 status read keeps alert", int'(alert_oe), 1);

    txn(OWN_WR, -1, ack, d);
    check("R5 other address no ack", int'(ack), 0);
    check("R5 alert unchanged", int'(alert_oe), 1);

    txn(ARA_RD, 0, ack, d);
    check("R6 acked before contention", int'(ack), 1);
    check("R6 released after lost bit", int'(d), 8'h7F);
    check("R6 no mask after lost arbitration", int'(alert_oe), 1);

    txn(ARA_RD, -1, ack, d);
    check("R7 ara acked", int'(ack), 1);
    check("R7 address", int'(d), int'(RET_EXP));
    check("R7 masked on empty status", int'(alert_oe), 0);

    txn(ARA_RD, -1, ack, d);
    check("R3 no ack once released", int'(ack), 0);

    pulse(8'h02, 0);
    check("R8 new bit clears mask", int'(alert_oe), 1);

    // R9: stall during the acknowledge bit
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(ARA_RD[i]);
    w(3);
    check("R9 ack driven before stall limit", int'(sda_oe), 1);
    w(TMO + 4);
    check("R9 sda released after stall", int'(sda_oe), 0);
    sda_m = 0; w(2); scl_m = 1; w(4); sda_m = 1; w(3);

    txn(ARA_RD, -1, ack, d);
    check("R9 recovers after timeout", int'(ack), 1);
    pulse('0, 1);
    txn(ARA_RD, -1, ack, d);
    check("R7 masked after status read", int'(alert_oe), 0);

    pin_mode = 2'd1; w(2);
    check("R4 comparator idle", int'(alert_oe), 0);
    pulse(8'h04, 0);
    check("R4 comparator follows status", int'(alert_oe), 1);
    txn(ARA_RD, -1, ack, d);
    check("R4 no ara ack in comparator", int'(ack), 0);
    pulse('0, 1);
    check("R8 read clears status", int'(alert_oe), 0);
    pulse(8'h08, 1);
    check("R8 set beats read", int'(alert_oe), 1);

    pin_mode = 2'd2; w(2);
    check("R4 tach mode released", int'(alert_oe), 0);
    txn(ARA_RD, -1, ack, d);
    check("R4 no ara ack in tach", int'(ack), 0);

    run = 0;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule